// File: doc/BRIEF.md
# Discriminator Configuration Bus Slave

This block is the bus-facing register slave of a multi-channel leading-edge discriminator card. It watches a VME-style parallel bus, decides whether an access is addressed to the card, and then either updates one write-only setting or returns one read-only identification word. The settings feed the channel logic directly: a per-channel 8-bit threshold, two 8-bit pulse-width words (one for each half of the channels), a majority level, and a 16-bit enable mask. A write to one particular offset fires a single-cycle test strobe. The strobe is global; the channel logic applies the enable mask to it.

The bus is modelled synchronously. An access is taken on the first clock edge at which the data strobe is seen high. The acknowledge and any read data appear in the following cycle for one cycle only. Four hex switches set the card's base address. The address modifier selects between 24-bit and 32-bit addressing. Address lines 9 to 15 take no part in decoding, so the 512-byte register page repeats throughout the 64 KB window. An activity output stays high for a fixed number of cycles after every acknowledged access so that it can drive a front-panel lamp.

Top module: `cfgBusSlave`

## Requirements
- R1: After reset every threshold, both width words, the majority level and the enable mask read zero at the outputs, and busDtack, testStrobe, accessLed and busRdData are all low.
- R2: Only address-modifier codes 0x39 and 0x3D (24-bit) and 0x09 and 0x0D (32-bit) are answered. With any other code there is no acknowledge and no setting changes.
- R3: In 24-bit mode busAddr[23:16] must equal baseSw[15:8] and busAddr[31:24] is ignored. In 32-bit mode busAddr[31:16] must equal baseSw[15:0]. On a mismatch there is no acknowledge and no setting changes.
- R4: busAddr[15:9] and busAddr[0] are ignored, so an offset reached with any value of bits 15:9 hits the same register. An access with busAddr[8]=1 is unmapped.
- R5: A write to offset 2*n (n < CHANNELS) loads busWrData[7:0] into the threshold of channel n, which appears on thrFlat[8n+7:8n].
- R6: A write to offset 0x40 loads widthLo and a write to 0x42 loads widthHi, each from busWrData[7:0]. A write to 0x48 loads majLevel from busWrData[7:0]. A write to 0x4A loads enMask from busWrData[15:0], where bit n = 1 enables channel n.
- R7: Any write to offset 0x4C raises testStrobe for exactly one cycle, the cycle in which busDtack is high, whatever the data. It changes no setting.
- R8: Reads return the identifiers 0xFAF5 at offset 0xFA, {manufacturer 6'b000010, module type 10'b0001010100} = 0x0854 at 0xFC, and {version, serial} at 0xFE (0x1123 with default parameters).
- R9: Reads of write-only or unmapped offsets are acknowledged and return zero. Writes to the identifier offsets or to unmapped offsets are acknowledged and change nothing. busRdData is zero in every cycle in which busDtack is low.
- R10: busDtack is high for exactly one cycle, the cycle after the edge at which busDs was first seen high. Holding busDs high for several cycles produces only one access.
- R11: accessLed goes high in the same cycle as busDtack and stays high for LED_HOLD cycles (8 by default). A new access restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baseSw | input | 16 | Base-address switch setting (four hex digits) |
| busAddr | input | 32 | Bus address |
| busAm | input | 6 | Address modifier |
| busDs | input | 1 | Data strobe, active high, synchronous |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, valid while busDtack is high |
| busDtack | output | 1 | Access acknowledge, one cycle |
| thrFlat | output | CHANNELS*8 | Per-channel thresholds, channel n at bits 8n+7:8n |
| widthLo | output | 8 | Pulse-width word for the lower half of the channels |
| widthHi | output | 8 | Pulse-width word for the upper half of the channels |
| majLevel | output | 8 | Majority level word |
| enMask | output | CHANNELS | Channel enable mask |
| testStrobe | output | 1 | One-cycle test pulse request |
| accessLed | output | 1 | Stretched access-activity flag |

## Verification
The bench targets the decode corners: modifier codes next to the legal ones, switch mismatches that show up in only one addressing mode, junk in the upper address byte during 24-bit accesses, and aliased offsets with bits 9 to 15 set. A decoder that compared the wrong address slice would either lose those 24-bit accesses or answer a foreign base. A decoder that included bit 8 in the alias would corrupt the enable mask, and the bench reads the mask back afterwards to catch this. Writes to identifier offsets are followed by a read-back, because a slave that latched them would return altered words. A held data strobe must yield exactly one test pulse; a level-triggered slave would fire on every cycle of it. The activity flag is counted cycle by cycle, which exposes an off-by-one in the stretch counter.

// File: rtl/cfgSlavePkg.sv
package cfgSlavePkg;

  // Address-modifier codes that the slave answers
  localparam logic [5:0] AM_STD_USER  = 6'h39;
  localparam logic [5:0] AM_STD_SUPER = 6'h3D;
  localparam logic [5:0] AM_EXT_USER  = 6'h09;
  localparam logic [5:0] AM_EXT_SUPER = 6'h0D;

  // Byte offsets within the register page
  localparam logic [7:0] OFF_WIDTH_LO = 8'h40;
  localparam logic [7:0] OFF_WIDTH_HI = 8'h42;
  localparam logic [7:0] OFF_MAJ      = 8'h48;
  localparam logic [7:0] OFF_MASK     = 8'h4A;
  localparam logic [7:0] OFF_TEST     = 8'h4C;
  localparam logic [7:0] OFF_ID_FIX   = 8'hFA;
  localparam logic [7:0] OFF_ID_MOD   = 8'hFC;
  localparam logic [7:0] OFF_ID_SER   = 8'hFE;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_THR,
    SEL_WLO,
    SEL_WHI,
    SEL_MAJ,
    SEL_MASK,
    SEL_TEST,
    SEL_IDFIX,
    SEL_IDMOD,
    SEL_IDSER
  } regSelE;

  // Strobes passed from the decode control to the register datapath
  typedef struct packed {
    logic       accept;
    logic       isWrite;
    regSelE     regSel;
    logic [7:0] wordIdx;
  } busStrobeT;

endpackage

// File: rtl/cfgSlaveCtrl.sv
module cfgSlaveCtrl
  import cfgSlavePkg::*;
#(
  parameter int CHANNELS = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [15:0]     baseSw,
  input  logic [31:0]     busAddr,
  input  logic [5:0]      busAm,
  input  logic            busDs,
  input  logic            busWrite,
  output busStrobeT       strobe
);

  localparam logic [8:0] THR_END = 9'(2 * CHANNELS);

  logic       dsPrev;
  logic       amOk;
  logic       isExt;
  logic       baseHit;
  logic [7:0] byteOff;
  regSelE     selNext;
  logic       unusedAddr;

  assign unusedAddr = ^{busAddr[15:9], busAddr[0]};

  // Edge detect on the data strobe: one access per assertion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dsPrev <= 1'b0;
    else       dsPrev <= busDs;
  end

  always_comb begin
    amOk  = 1'b0;
    isExt = 1'b0;
    case (busAm)
      AM_STD_USER, AM_STD_SUPER: amOk = 1'b1;
      AM_EXT_USER, AM_EXT_SUPER: begin
        amOk  = 1'b1;
        isExt = 1'b1;
      end
      default: amOk = 1'b0;
    endcase
  end

  always_comb begin
    if (isExt) baseHit = (busAddr[31:16] == baseSw);
    else       baseHit = (busAddr[23:16] == baseSw[15:8]);
  end

  assign byteOff = {busAddr[7:1], 1'b0};

  always_comb begin
    selNext = SEL_NONE;
    if (!busAddr[8]) begin
      if ({1'b0, byteOff} < THR_END) begin
        selNext = SEL_THR;
      end else begin
        case (byteOff)
          OFF_WIDTH_LO: selNext = SEL_WLO;
          OFF_WIDTH_HI: selNext = SEL_WHI;
          OFF_MAJ:      selNext = SEL_MAJ;
          OFF_MASK:     selNext = SEL_MASK;
          OFF_TEST:     selNext = SEL_TEST;
          OFF_ID_FIX:   selNext = SEL_IDFIX;
          OFF_ID_MOD:   selNext = SEL_IDMOD;
          OFF_ID_SER:   selNext = SEL_IDSER;
          default:      selNext = SEL_NONE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.accept  = busDs && !dsPrev && amOk && baseHit;
    strobe.isWrite = busWrite;
    strobe.regSel  = selNext;
    strobe.wordIdx = busAddr[8:1];
  end

endmodule

// File: rtl/cfgSlaveData.sv
module cfgSlaveData
  import cfgSlavePkg::*;
#(
  parameter int          CHANNELS    = 16,
  parameter int          LED_HOLD    = 8,
  parameter logic [5:0]  MFR_CODE    = 6'b000010,
  parameter logic [9:0]  MODULE_CODE = 10'b0001010100,
  parameter logic [3:0]  VERSION_ID  = 4'h1,
  parameter logic [11:0] SERIAL_ID   = 12'h123
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  busStrobeT               strobe,
  input  logic [15:0]             busWrData,
  output logic [15:0]             busRdData,
  output logic                    busDtack,
  output logic [CHANNELS*8-1:0]   thrFlat,
  output logic [7:0]              widthLo,
  output logic [7:0]              widthHi,
  output logic [7:0]              majLevel,
  output logic [CHANNELS-1:0]     enMask,
  output logic                    testStrobe,
  output logic                    accessLed
);

  localparam int          CNT_W     = $clog2(LED_HOLD + 1);
  localparam logic [15:0] ID_FIXED  = 16'hFAF5;
  localparam logic [15:0] ID_MODULE = {MFR_CODE, MODULE_CODE};
  localparam logic [15:0] ID_SERIAL = {VERSION_ID, SERIAL_ID};

  logic             doWrite;
  logic             doRead;
  logic [CNT_W-1:0] ledCnt;
  logic [15:0]      rdNext;

  assign doWrite = strobe.accept && strobe.isWrite;
  assign doRead  = strobe.accept && !strobe.isWrite;

  // Per-channel threshold registers
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_thr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        thrFlat[ch*8 +: 8] <= '0;
      end else if (doWrite && strobe.regSel == SEL_THR &&
                   strobe.wordIdx == 8'(ch)) begin
        thrFlat[ch*8 +: 8] <= busWrData[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthLo  <= '0;
      widthHi  <= '0;
      majLevel <= '0;
      enMask   <= '0;
    end else if (doWrite) begin
      case (strobe.regSel)
        SEL_WLO:  widthLo  <= busWrData[7:0];
        SEL_WHI:  widthHi  <= busWrData[7:0];
        SEL_MAJ:  majLevel <= busWrData[7:0];
        SEL_MASK: enMask   <= busWrData[CHANNELS-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdNext = '0;
    if (doRead) begin
      case (strobe.regSel)
        SEL_IDFIX: rdNext = ID_FIXED;
        SEL_IDMOD: rdNext = ID_MODULE;
        SEL_IDSER: rdNext = ID_SERIAL;
        default:   rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData  <= '0;
      busDtack   <= 1'b0;
      testStrobe <= 1'b0;
    end else begin
      busRdData  <= rdNext;
      busDtack   <= strobe.accept;
      testStrobe <= doWrite && (strobe.regSel == SEL_TEST);
    end
  end

  // Activity stretch counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ledCnt <= '0;
    else if (strobe.accept)    ledCnt <= CNT_W'(LED_HOLD);
    else if (ledCnt != '0)     ledCnt <= ledCnt - 1'b1;
  end

  assign accessLed = (ledCnt != '0);

endmodule

// File: rtl/cfgBusSlave.sv
module cfgBusSlave
  import cfgSlavePkg::*;
#(
  parameter int          CHANNELS   = 16,
  parameter int          LED_HOLD   = 8,
  parameter logic [3:0]  VERSION_ID = 4'h1,
  parameter logic [11:0] SERIAL_ID  = 12'h123
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:0]           baseSw,
  input  logic [31:0]           busAddr,
  input  logic [5:0]            busAm,
  input  logic                  busDs,
  input  logic                  busWrite,
  input  logic [15:0]           busWrData,
  output logic [15:0]           busRdData,
  output logic                  busDtack,
  output logic [CHANNELS*8-1:0] thrFlat,
  output logic [7:0]            widthLo,
  output logic [7:0]            widthHi,
  output logic [7:0]            majLevel,
  output logic [CHANNELS-1:0]   enMask,
  output logic                  testStrobe,
  output logic                  accessLed
);

  busStrobeT strobe;

  cfgSlaveCtrl #(.CHANNELS(CHANNELS)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .baseSw   (baseSw),
    .busAddr  (busAddr),
    .busAm    (busAm),
    .busDs    (busDs),
    .busWrite (busWrite),
    .strobe   (strobe)
  );

  cfgSlaveData #(
    .CHANNELS   (CHANNELS),
    .LED_HOLD   (LED_HOLD),
    .VERSION_ID (VERSION_ID),
    .SERIAL_ID  (SERIAL_ID)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .busDtack   (busDtack),
    .thrFlat    (thrFlat),
    .widthLo    (widthLo),
    .widthHi    (widthHi),
    .majLevel   (majLevel),
    .enMask     (enMask),
    .testStrobe (testStrobe),
    .accessLed  (accessLed)
  );

endmodule

// File: rtl/cfgSlaveChecker.sv
module cfgSlaveChecker #(
  parameter int CHANNELS = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [15:0]           busRdData,
  input logic                  busDtack,
  input logic                  testStrobe,
  input logic                  accessLed,
  input logic [CHANNELS-1:0]   enMask,
  input logic [CHANNELS*8-1:0] thrFlat,
  input logic [7:0]            widthLo
);

  // R10: acknowledge never lasts two cycles
  a_r10_dtack_single: assert property (@(posedge clk) disable iff (!rstN)
    busDtack |=> !busDtack);

  // R9: read bus quiet outside acknowledged cycles
  a_r9_rd_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busDtack |-> (busRdData == 16'h0000));

  // R7: test strobe is one cycle and coincides with an acknowledge
  a_r7_test_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    testStrobe |=> !testStrobe);
  a_r7_test_acked: assert property (@(posedge clk) disable iff (!rstN)
    testStrobe |-> busDtack);

  // R6: enable mask only moves alongside an acknowledge
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busDtack |-> $stable(enMask));

  // R5: thresholds only move alongside an acknowledge
  a_r5_thr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busDtack |-> $stable(thrFlat));

  // R6: width word only moves alongside an acknowledge
  a_r6_width_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busDtack |-> $stable(widthLo));

  // R11: activity flag is lit whenever an access is acknowledged
  a_r11_led_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    busDtack |-> accessLed);

endmodule

bind cfgBusSlave cfgSlaveChecker #(.CHANNELS(CHANNELS)) chk_i (.*);

// File: tb/cfgBusSlave_tb_top.sv
`timescale 1ns/1ps
module cfgBusSlave_tb_top;

  localparam int CHANNELS = 16;
  localparam int LED_HOLD = 8;
  localparam logic [15:0] BASE = 16'hA5C3;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic [15:0]           baseSw = BASE;
  logic [31:0]           busAddr = '0;
  logic [5:0]            busAm = '0;
  logic                  busDs = 1'b0;
  logic                  busWrite = 1'b0;
  logic [15:0]           busWrData = '0;
  logic [15:0]           busRdData;
  logic                  busDtack;
  logic [CHANNELS*8-1:0] thrFlat;
  logic [7:0]            widthLo;
  logic [7:0]            widthHi;
  logic [7:0]            majLevel;
  logic [CHANNELS-1:0]   enMask;
  logic                  testStrobe;
  logic                  accessLed;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  cfgBusSlave #(.CHANNELS(CHANNELS), .LED_HOLD(LED_HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .baseSw(baseSw), .busAddr(busAddr),
    .busAm(busAm), .busDs(busDs), .busWrite(busWrite),
    .busWrData(busWrData), .busRdData(busRdData), .busDtack(busDtack),
    .thrFlat(thrFlat), .widthLo(widthLo), .widthHi(widthHi),
    .majLevel(majLevel), .enMask(enMask), .testStrobe(testStrobe),
    .accessLed(accessLed)
  );

  typedef struct packed {
    logic [5:0]  am;
    logic [31:0] addr;
    logic        wr;
    logic [15:0] data;
    logic        expAck;
    logic [15:0] expRd;
  } vecT;

  localparam int NVEC = 17;
  localparam vecT VECS [NVEC] = '{
    '{6'h39, 32'h00A50006, 1'b1, 16'h0033, 1'b1, 16'h0000}, // R5 ch3, 24-bit
    '{6'h09, 32'hA5C3001E, 1'b1, 16'h00FF, 1'b1, 16'h0000}, // R5 ch15, 32-bit
    '{6'h3D, 32'h00A50040, 1'b1, 16'h0011, 1'b1, 16'h0000}, // R6 widthLo
    '{6'h0D, 32'hA5C30042, 1'b1, 16'h00EE, 1'b1, 16'h0000}, // R6 widthHi
    '{6'h39, 32'h00A53048, 1'b1, 16'h0038, 1'b1, 16'h0000}, // R4 alias to maj
    '{6'h39, 32'h00A5004A, 1'b1, 16'h8001, 1'b1, 16'h0000}, // R6 mask
    '{6'h39, 32'h00A500FA, 1'b0, 16'h0000, 1'b1, 16'hFAF5}, // R8 fixed id
    '{6'h09, 32'hA5C300FC, 1'b0, 16'h0000, 1'b1, 16'h0854}, // R8 module id
    '{6'h0D, 32'hA5C3FEFE, 1'b0, 16'h0000, 1'b1, 16'h1123}, // R8 serial id, alias
    '{6'h39, 32'h00A50040, 1'b0, 16'h0000, 1'b1, 16'h0000}, // R9 read write-only
    '{6'h39, 32'h00A50080, 1'b0, 16'h0000, 1'b1, 16'h0000}, // R9 unmapped read
    '{6'h3A, 32'h00A5004A, 1'b1, 16'hFFFF, 1'b0, 16'h0000}, // R2 bad modifier
    '{6'h39, 32'h00A6004A, 1'b1, 16'hFFFF, 1'b0, 16'h0000}, // R3 24-bit miss
    '{6'h09, 32'hA4C3004A, 1'b1, 16'hFFFF, 1'b0, 16'h0000}, // R3 32-bit miss
    '{6'h39, 32'h00A500FC, 1'b1, 16'hFFFF, 1'b1, 16'h0000}, // R9 write to id
    '{6'h39, 32'h00A5014A, 1'b1, 16'hFFFF, 1'b1, 16'h0000}, // R4 bit8 unmapped
    '{6'h39, 32'hFFA50004, 1'b1, 16'h0044, 1'b1, 16'h0000}  // R3 upper byte ignored
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One access: drive at a falling edge, sample at the next falling edge
  task automatic access(input logic [5:0] am, input logic [31:0] addr,
                        input logic wr, input logic [15:0] data,
                        output logic ack, output logic [15:0] rd,
                        output logic tst);
    @(negedge clk);
    busAm = am; busAddr = addr; busWrite = wr; busWrData = data; busDs = 1'b1;
    @(negedge clk);
    ack = busDtack; rd = busRdData; tst = testStrobe;
    busDs = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic        ack;
    logic [15:0] rd;
    logic        tst;
    int          pulses;
    int          litCycles;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "thrFlat", 32'(thrFlat == '0), 32'd1);
    check("R1", "widthLo", 32'(widthLo), 32'h0);
    check("R1", "widthHi", 32'(widthHi), 32'h0);
    check("R1", "majLevel", 32'(majLevel), 32'h0);
    check("R1", "enMask", 32'(enMask), 32'h0);
    check("R1", "dtack/test/led", 32'({busDtack, testStrobe, accessLed}), 32'h0);
    check("R1", "rdData", 32'(busRdData), 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].am, VECS[i].addr, VECS[i].wr, VECS[i].data, ack, rd, tst);
      check("R2/R3/R4/R8/R9", $sformatf("vector %0d ack", i), 32'(ack), 32'(VECS[i].expAck));
      check("R8/R9", $sformatf("vector %0d rdData", i), 32'(rd), 32'(VECS[i].expRd));
      check("R7", $sformatf("vector %0d no test", i), 32'(tst), 32'h0);
    end

    // Settings after the table
    check("R5", "thr ch3", 32'(thrFlat[3*8 +: 8]), 32'h33);
    check("R5", "thr ch15", 32'(thrFlat[15*8 +: 8]), 32'hFF);
    check("R3", "thr ch2 via junk upper byte", 32'(thrFlat[2*8 +: 8]), 32'h44);
    check("R5", "thr ch0 untouched", 32'(thrFlat[0 +: 8]), 32'h0);
    check("R6", "widthLo", 32'(widthLo), 32'h11);
    check("R6", "widthHi", 32'(widthHi), 32'hEE);
    check("R4", "majLevel via alias", 32'(majLevel), 32'h38);
    check("R2", "enMask untouched by rejected writes", 32'(enMask), 32'h8001);

    // R9: identifier not altered by write
    access(6'h39, 32'h00A500FC, 1'b0, 16'h0, ack, rd, tst);
    check("R9", "id after write", 32'(rd), 32'h0854);

    // R7: test strobe, data independent, no setting change
    access(6'h39, 32'h00A5004C, 1'b1, 16'h0000, ack, rd, tst);
    check("R7", "test strobe data 0", 32'(tst), 32'h1);
    access(6'h0D, 32'hA5C3004C, 1'b1, 16'hABCD, ack, rd, tst);
    check("R7", "test strobe data ABCD", 32'(tst), 32'h1);
    check("R7", "mask after test", 32'(enMask), 32'h8001);
    check("R7", "maj after test", 32'(majLevel), 32'h38);

    // R7: read of the test offset fires nothing
    access(6'h39, 32'h00A5004C, 1'b0, 16'h0, ack, rd, tst);
    check("R7", "read test offset", 32'({ack, tst}), 32'h2);

    // R10 and R11: held strobe gives one access; stretch length
    repeat (LED_HOLD + 2) @(negedge clk);
    pulses = 0;
    litCycles = 0;
    busAm = 6'h39; busAddr = 32'h00A5004C; busWrite = 1'b1; busWrData = 16'h5;
    busDs = 1'b1;
    for (int c = 0; c < LED_HOLD + 6; c++) begin
      @(negedge clk);
      if (c == 3) busDs = 1'b0;
      if (testStrobe) pulses++;
      if (accessLed) litCycles++;
      if (c == 0) check("R10", "dtack first cycle", 32'(busDtack), 32'h1);
      if (c == 1) check("R10", "dtack second cycle", 32'(busDtack), 32'h0);
    end
    check("R10", "one test pulse for held strobe", 32'(pulses), 32'd1);
    check("R11", "led stretch cycles", 32'(litCycles), 32'(LED_HOLD));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule